// File: doc/BRIEF.md
# UART Receive-Level Interrupt and Line Status Unit

This unit holds the interrupt and line-status logic of a FIFO-equipped UART. It does not store characters. It models the receive FIFO as an occupancy count plus a three-bit error tag for each entry. It compares that count against a programmable trigger threshold. It keeps the line status byte and arbitrates three interrupt sources into an identification byte and one interrupt pin.

The receiver pulses `rx_push` with the error flags of each completed character, and the data path pulses `rx_pop` when a character is taken. The transmitter reports its FIFO-empty and shift-register-empty levels. The CPU writes the enable nibble and the FIFO control byte, and reads any of four register images through `rd_sel`. A read strobe on the status image clears the sticky error reporting.

The source arbiter is a four-state machine. The states are `SRC_NONE`, `SRC_LINE`, `SRC_RXDATA` and `SRC_TXEMPTY`. On every clock the machine moves from whatever state it holds to the highest-priority source that is pending and enabled in that cycle. If no source is pending and enabled, it moves to `SRC_NONE`. The interrupt output and the identification byte are decoded from the registered state, so they follow their causes by one clock.

Top module: `uart_irq_status`

## Requirements
- R1: With receive-data enable (enable bit 0) set and the count at or above the effective trigger level in one cycle, `irq` is 1 and the identification low nibble reads 0100 in the next cycle, unless a line-status source is pending.
- R2: The receive-data identification and the interrupt drop together, one cycle after the count falls below the trigger level.
- R3: Status bit 0 becomes 1 in the cycle after a push and stays 1 until the last stored entry is popped.
- R4: With all four enable bits 0, `irq` stays 0 while every status bit keeps updating.
- R5: Status bits 2, 3 and 4 show the parity, framing and break tags of the entry at the FIFO head. A status read hides them until the head changes.
- R6: A push while the count equals the depth and no pop occurs discards the character and sets status bit 1. A status read clears status bit 1.
- R7: Status bit 5 equals `tx_fifo_empty`. Status bit 6 is 1 only when both transmit empties are 1.
- R8: Status bit 7 is 1 while any stored entry carries a nonzero error tag.
- R9: After reset the enables are 0, the FIFOs are disabled, the identification reads 0x01, and the status reads 0 apart from bits 5 and 6.
- R10: FIFO control bit 0 enables the FIFOs. Bits 7:6 select a trigger level of 1, 4, 8 or 14 for codes 00 to 11. With the FIFOs disabled the level is 1. A newly written level that the count already meets raises `irq` one cycle after the write takes effect.
- R11: The priority order is line status first (enable bit 2 and any of status bits 1 to 4, code 0110), then receive data (code 0100), then transmit empty (enable bit 1 and status bit 5, code 0010). Code 0001 means nothing is pending. Identification bits 7:6 are 11 when the FIFOs are enabled and 00 otherwise.
- R12: The value of `rd_sel` picks the read image: 0 gives the enables in bits 3:0, 1 gives the identification, 2 gives the status, and 3 gives the control image (trigger code in bits 7:6, enable in bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Completed character enters the receive FIFO |
| rx_err_par | input | 1 | Parity error tag of the pushed character |
| rx_err_frm | input | 1 | Framing error tag of the pushed character |
| rx_err_brk | input | 1 | Break tag of the pushed character |
| rx_pop | input | 1 | Head character removed from the receive FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_empty | input | 1 | Transmit shift register idle |
| ier_we | input | 1 | Write strobe for the enable nibble |
| ier_wdata | input | 4 | Enable nibble write data |
| fcr_we | input | 1 | Write strobe for FIFO control |
| fcr_wdata | input | 8 | FIFO control write data |
| rd_en | input | 1 | Read strobe (side effect for status image only) |
| rd_sel | input | 2 | Read image select |
| rd_data | output | 8 | Read image data |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in one cycle. In the first, a line-status error and a receive level at its trigger are both pending. The bench provokes this by pushing an errored character with the trigger at 1 and the transmitter empty. It then expects code 0110 first, code 0100 after a clearing status read, and code 0010 after the pop. In the second, a push arrives at a full FIFO. The bench judges this by checking that the error tag of the discarded character never reaches status bit 7, and that the data-ready bit falls on exactly the sixteenth pop.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXDATA,
        SRC_TXEMPTY
    } irq_state_e;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    localparam logic [3:0] ID_NONE    = 4'h1;
    localparam logic [3:0] ID_LINE    = 4'h6;
    localparam logic [3:0] ID_RXDATA  = 4'h4;
    localparam logic [3:0] ID_TXEMPTY = 4'h2;

    function automatic logic [4:0] trig_bytes(input logic [1:0] code);
        logic [4:0] r;
        unique case (code)
            2'b00:   r = 5'd1;
            2'b01:   r = 5'd4;
            2'b10:   r = 5'd8;
            default: r = 5'd14;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uirq_ctrl.sv
`timescale 1ns/1ps
module uirq_ctrl #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_we,
    input  logic [3:0]       ier_wdata,
    input  logic             fcr_we,
    input  logic [7:0]       fcr_wdata,
    output logic [3:0]       ier_q,
    output logic             fifo_en,
    output logic [1:0]       trig_code,
    output logic [CNT_W-1:0] trig_lvl
);
    import uirq_pkg::*;

    logic unused_fcr_bits;
    assign unused_fcr_bits = ^fcr_wdata[5:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q     <= '0;
            fifo_en   <= 1'b0;
            trig_code <= 2'b00;
        end else begin
            if (ier_we) ier_q <= ier_wdata;
            if (fcr_we) begin
                fifo_en   <= fcr_wdata[0];
                trig_code <= fcr_wdata[7:6];
            end
        end
    end

    always_comb begin
        if (fifo_en) trig_lvl = CNT_W'(trig_bytes(trig_code));
        else         trig_lvl = CNT_W'(1);
    end

endmodule

// File: rtl/uirq_rx_track.sv
`timescale 1ns/1ps
module uirq_rx_track #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_push,
    input  uirq_pkg::rx_err_t  rx_err,
    input  logic               rx_pop,
    input  logic               lsr_rd,
    output logic [CNT_W-1:0]   rx_count,
    output uirq_pkg::rx_err_t  head_err,
    output logic               overrun,
    output logic               fifo_err
);
    import uirq_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [CNT_W-1:0] count_q, err_cnt_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic             mask_q, ovr_q;
    rx_err_t          tag_q [DEPTH];
    rx_err_t          head_raw;
    logic             pop_ok, push_ok, not_empty;

    assign not_empty = (count_q != '0);
    assign pop_ok    = rx_pop && not_empty;
    assign push_ok   = rx_push && ((count_q != FULL_CNT) || pop_ok);
    assign head_raw  = tag_q[rd_ptr_q];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    // per-entry error tag storage
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tag_q[gi] <= '0;
            else if (push_ok && (wr_ptr_q == PTR_W'(gi)))
                tag_q[gi] <= rx_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            err_cnt_q <= '0;
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            mask_q    <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
            unique case ({push_ok && (|rx_err), pop_ok && (|head_raw)})
                2'b10:   err_cnt_q <= err_cnt_q + CNT_W'(1);
                2'b01:   err_cnt_q <= err_cnt_q - CNT_W'(1);
                default: err_cnt_q <= err_cnt_q;
            endcase
            if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            if (pop_ok)
                mask_q <= 1'b0;
            else if (lsr_rd && not_empty)
                mask_q <= 1'b1;
            if (rx_push && !push_ok)
                ovr_q <= 1'b1;
            else if (lsr_rd)
                ovr_q <= 1'b0;
        end
    end

    assign rx_count = count_q;
    assign head_err = (not_empty && !mask_q) ? head_raw : '0;
    assign overrun  = ovr_q;
    assign fifo_err = (err_cnt_q != '0);

endmodule

// File: rtl/uirq_arb.sv
`timescale 1ns/1ps
module uirq_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ier_q,
    input  logic       fifo_en,
    input  logic       line_err,
    input  logic       rx_at_trig,
    input  logic       tx_empty,
    output logic       irq,
    output logic [7:0] iir
);
    import uirq_pkg::*;

    irq_state_e state_q, state_d;
    logic [3:0] id_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (ier_q[2] && line_err)        state_d = SRC_LINE;
        else if (ier_q[0] && rx_at_trig) state_d = SRC_RXDATA;
        else if (ier_q[1] && tx_empty)   state_d = SRC_TXEMPTY;
        else                             state_d = SRC_NONE;
    end

    always_comb begin
        unique case (state_q)
            SRC_LINE:    begin id_code = ID_LINE;    irq = 1'b1; end
            SRC_RXDATA:  begin id_code = ID_RXDATA;  irq = 1'b1; end
            SRC_TXEMPTY: begin id_code = ID_TXEMPTY; irq = 1'b1; end
            default:     begin id_code = ID_NONE;    irq = 1'b0; end
        endcase
        iir = {fifo_en, fifo_en, 2'b00, id_code};
    end

endmodule

// File: rtl/uart_irq_status.sv
`timescale 1ns/1ps
module uart_irq_status #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic       rx_err_par,
    input  logic       rx_err_frm,
    input  logic       rx_err_brk,
    input  logic       rx_pop,
    input  logic       tx_fifo_empty,
    input  logic       tx_shift_empty,
    input  logic       ier_we,
    input  logic [3:0] ier_wdata,
    input  logic       fcr_we,
    input  logic [7:0] fcr_wdata,
    input  logic       rd_en,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       irq
);
    import uirq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [3:0]       ier_q;
    logic             fifo_en;
    logic [1:0]       trig_code;
    logic [CNT_W-1:0] trig_lvl, rx_count;
    rx_err_t          push_err, head_err;
    logic             overrun, fifo_err, lsr_rd;
    logic [7:0]       lsr_w, iir_w;

    assign push_err = '{brk: rx_err_brk, frm: rx_err_frm, par: rx_err_par};
    assign lsr_rd   = rd_en && (rd_sel == 2'd2);

    uirq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ier_we(ier_we), .ier_wdata(ier_wdata),
        .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .ier_q(ier_q), .fifo_en(fifo_en),
        .trig_code(trig_code), .trig_lvl(trig_lvl)
    );

    uirq_rx_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_err(push_err), .rx_pop(rx_pop),
        .lsr_rd(lsr_rd), .rx_count(rx_count), .head_err(head_err),
        .overrun(overrun), .fifo_err(fifo_err)
    );

    assign lsr_w = {fifo_err,
                    tx_fifo_empty && tx_shift_empty,
                    tx_fifo_empty,
                    head_err.brk, head_err.frm, head_err.par,
                    overrun,
                    rx_count != '0};

    uirq_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .ier_q(ier_q), .fifo_en(fifo_en),
        .line_err(|lsr_w[4:1]),
        .rx_at_trig(rx_count >= trig_lvl),
        .tx_empty(lsr_w[5]),
        .irq(irq), .iir(iir_w)
    );

    always_comb begin
        unique case (rd_sel)
            2'd0:    rd_data = {4'b0000, ier_q};
            2'd1:    rd_data = iir_w;
            2'd2:    rd_data = lsr_w;
            default: rd_data = {trig_code, 5'b00000, fifo_en};
        endcase
    end

endmodule

// File: rtl/uirq_checker.sv
`timescale 1ns/1ps
module uirq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [3:0]       ier_q,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] trig_lvl,
    input logic [7:0]       lsr,
    input logic [7:0]       iir,
    input logic             irq
);
    p_rxdata_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ier_q[0] && (rx_count >= trig_lvl)) |-> irq);

    p_rxdata_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[3:0] == 4'h4) |-> $past(rx_count >= trig_lvl));

    p_dready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> lsr[0]);

    p_polled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ier_q == 4'h0) && ($past(ier_q) == 4'h0)) |-> !irq);

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && (rx_count == CNT_W'(DEPTH))) |=> lsr[1]);

    p_tx_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    p_line_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[3:0] == 4'h4) |-> !$past(ier_q[2] && (|lsr[4:1])));
endmodule

bind uart_irq_status uirq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
    .ier_q(ier_q), .rx_count(rx_count), .trig_lvl(trig_lvl),
    .lsr(lsr_w), .iir(iir_w), .irq(irq)
);

// File: tb/tb_uart_irq_status.sv
`timescale 1ns/1ps
module tb_uart_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_err_par = 0, rx_err_frm = 0, rx_err_brk = 0, rx_pop = 0;
    logic       tx_fifo_empty = 1, tx_shift_empty = 1;
    logic       ier_we = 0, fcr_we = 0, rd_en = 0;
    logic [3:0] ier_wdata = '0;
    logic [7:0] fcr_wdata = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    uart_irq_status dut (.*);

    // {push, pop, err{brk,frm,par}, expected status, expected identification}
    localparam logic [20:0] VEC [13] = '{
        {1'b1, 1'b0, 3'b000, 8'h01, 8'hC1},
        {1'b1, 1'b0, 3'b000, 8'h01, 8'hC1},
        {1'b1, 1'b0, 3'b001, 8'h81, 8'hC1},
        {1'b1, 1'b0, 3'b000, 8'h81, 8'hC4},
        {1'b0, 1'b1, 3'b000, 8'h81, 8'hC1},
        {1'b0, 1'b1, 3'b000, 8'h85, 8'hC6},
        {1'b0, 1'b1, 3'b000, 8'h01, 8'hC1},
        {1'b1, 1'b0, 3'b010, 8'h81, 8'hC1},
        {1'b0, 1'b1, 3'b000, 8'h89, 8'hC6},
        {1'b0, 1'b1, 3'b000, 8'h00, 8'hC1},
        {1'b0, 1'b1, 3'b000, 8'h00, 8'hC1},
        {1'b1, 1'b0, 3'b100, 8'h91, 8'hC6},
        {1'b0, 1'b1, 3'b000, 8'h00, 8'hC1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    task automatic op(input bit push, input bit pop, input logic [2:0] e);
        rx_push = push; rx_pop = pop;
        {rx_err_brk, rx_err_frm, rx_err_par} = e;
        tick();
        rx_push = 0; rx_pop = 0;
        {rx_err_brk, rx_err_frm, rx_err_par} = 3'b000;
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_we = 1; ier_wdata = v; tick(); ier_we = 0;
    endtask

    task automatic wr_fcr(input logic [7:0] v);
        fcr_we = 1; fcr_wdata = v; tick(); fcr_we = 0;
    endtask

    task automatic lsr_read();
        rd_sel = 2'd2; rd_en = 1; tick(); rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R9 / R12 reset images
        peek(2'd0, v); chk("R9 enables after reset", v, 8'h00);
        peek(2'd1, v); chk("R9 identification after reset", v, 8'h01);
        peek(2'd2, v); chk("R9 status after reset", v, 8'h60);
        peek(2'd3, v); chk("R12 control image after reset", v, 8'h00);
        chk("R9 irq after reset", {7'b0, irq}, 8'h00);

        tx_fifo_empty = 0; tx_shift_empty = 0;
        wr_fcr(8'h41);
        wr_ier(4'h5);
        peek(2'd0, v); chk("R12 enable image", v, 8'h05);

        // table walk: R1 R2 R3 R5 R8 R11
        for (int i = 0; i < 13; i++) begin
            op(VEC[i][20], VEC[i][19], VEC[i][18:16]);
            tick();
            peek(2'd2, v); chk($sformatf("R3/R5/R8 status row %0d", i), v, VEC[i][15:8]);
            peek(2'd1, v); chk($sformatf("R1/R2/R11 identification row %0d", i), v, VEC[i][7:0]);
        end

        // R10: new trigger level already met
        for (int i = 0; i < 8; i++) op(1, 0, 3'b000);
        wr_fcr(8'hC1);
        tick();
        chk("R10 level 14 not met", {7'b0, irq}, 8'h00);
        wr_fcr(8'h81);
        chk("R10 irq not yet raised in write cycle", {7'b0, irq}, 8'h00);
        tick();
        chk("R10 irq raised next cycle", {7'b0, irq}, 8'h01);
        peek(2'd1, v); chk("R10 receive-data code", v, 8'hC4);
        peek(2'd3, v); chk("R12 control image", v, 8'h81);

        // R2: falling below the level
        op(0, 1, 3'b000);
        chk("R2 irq still high one cycle", {7'b0, irq}, 8'h01);
        tick();
        chk("R2 irq cleared", {7'b0, irq}, 8'h00);
        peek(2'd1, v); chk("R2 identification cleared", v, 8'hC1);

        // R4: polled mode
        wr_ier(4'h0);
        op(1, 0, 3'b000);
        tick();
        chk("R4 irq low in polled mode", {7'b0, irq}, 8'h00);
        peek(2'd2, v); chk("R4 status still live", v, 8'h01);

        // R10: FIFOs disabled -> level 1
        wr_ier(4'h1);
        wr_fcr(8'h00);
        tick();
        chk("R10 disabled-FIFO irq", {7'b0, irq}, 8'h01);
        peek(2'd1, v); chk("R11 code without FIFO", v, 8'h04);
        wr_ier(4'h0);
        wr_fcr(8'hC1);
        for (int i = 0; i < 8; i++) op(0, 1, 3'b000);
        peek(2'd2, v); chk("R3 drained", v, 8'h00);

        // R6: overrun
        for (int i = 0; i < 16; i++) op(1, 0, 3'b000);
        op(1, 0, 3'b001);
        peek(2'd2, v); chk("R6 overrun set, tag discarded", v, 8'h03);
        lsr_read();
        peek(2'd2, v); chk("R6 overrun cleared by read", v, 8'h01);
        for (int i = 0; i < 15; i++) op(0, 1, 3'b000);
        peek(2'd2, v); chk("R3 ready after 15 pops", v, 8'h01);
        op(0, 1, 3'b000);
        peek(2'd2, v); chk("R6 count held at depth", v, 8'h00);

        // R5: head error hidden after read
        op(1, 0, 3'b001);
        peek(2'd2, v); chk("R5 head parity shown", v, 8'h85);
        lsr_read();
        peek(2'd2, v); chk("R5 hidden after read", v, 8'h81);
        op(1, 0, 3'b000);
        peek(2'd2, v); chk("R5 still hidden, R8 set", v, 8'h81);
        op(0, 1, 3'b000);
        peek(2'd2, v); chk("R8 cleared with errored pop", v, 8'h01);
        op(0, 1, 3'b000);

        // R11: priority with three sources
        wr_fcr(8'h01);
        wr_ier(4'h7);
        tx_fifo_empty = 1;
        op(1, 0, 3'b010);
        tick();
        peek(2'd1, v); chk("R11 line status first", v, 8'hC6);
        lsr_read();
        tick();
        peek(2'd1, v); chk("R11 receive data second", v, 8'hC4);
        op(0, 1, 3'b000);
        tick();
        peek(2'd1, v); chk("R11 transmit empty third", v, 8'hC2);
        chk("R11 irq high", {7'b0, irq}, 8'h01);
        tx_fifo_empty = 0;
        tick(); tick();
        peek(2'd1, v); chk("R11 nothing pending", v, 8'hC1);

        // R7: transmit empties
        tx_fifo_empty = 1; tx_shift_empty = 0;
        #0.5;
        peek(2'd2, v); chk("R7 FIFO empty only", v, 8'h20);
        tx_shift_empty = 1;
        #0.5;
        peek(2'd2, v); chk("R7 both empty", v, 8'h60);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule